// File: doc/BRIEF.md
# Debug Entry and Fault Recorder

This block holds the debug control word of a processor core together with a fault status register and a fault address register. The core and the data-breakpoint comparators report events to it as single-cycle strobes: a data-breakpoint hit, the execution of a breakpoint instruction, a prefetch abort and a data abort. The block also compares the current PC against two instruction-breakpoint registers of its own. From these events it records why the core entered debug, records fault information, and tells the core whether a breakpoint instruction traps or has to complete as a no-op.

All recording depends on the global enable bit in the debug control word. With the enable set, an entry event writes a method-of-entry code into the control word and raises a one-cycle trap pulse. Faults from a breakpoint instruction, a prefetch abort or a multi-word transfer also update the status and address registers. With the enable clear, the control word and fault registers keep their values. A breakpoint instruction then raises a no-op pulse in place of a trap. The three configuration registers are written through a small select/write-enable port. Every output is registered, so each result appears one clock after the event that causes it.

Top module: `dbg_entry_rec`

## Requirements
- R1: After reset, `dbg_ctrl`, `fault_status`, `fault_addr`, `trap` and `bkpt_nop` are all zero, and both instruction-breakpoint registers are zero.
- R2: A write with `cfg_we` high and `cfg_sel` = 0 loads `cfg_wdata` into the debug control word, which appears on `dbg_ctrl` the next cycle. Bit 31 of that word is the global debug enable.
- R3: With the enable set, an entry event writes a method-of-entry code into `dbg_ctrl` bits 4:2 and leaves every other bit unchanged. The code is 1 for an instruction breakpoint, 2 for `dbp_hit` and 3 for `bkpt_exec`.
- R4: With the enable clear, entry events leave `dbg_ctrl` unchanged.
- R5: `cfg_sel` = 1 and `cfg_sel` = 2 write the two instruction-breakpoint registers. An instruction breakpoint fires when `pc_valid` is high, bit 0 of a register (its enable) is set, and `pc` bits 31:2 equal that register's bits 31:2. Either register can fire it.
- R6: `trap` is a one-cycle pulse, one clock after an instruction breakpoint, `dbp_hit` or `bkpt_exec` seen while the enable is set. No entry event raises it while the enable is clear.
- R7: `bkpt_exec` with the enable clear gives a one-cycle `bkpt_nop` pulse one clock later and no trap. With the enable set, `bkpt_nop` stays low.
- R8: With the enable set, `bkpt_exec` or `pabt` loads `fault_status` = 0x400 and `fault_addr` = `pc`.
- R9: With the enable set, a data abort loads `fault_status` = 0x001 and `fault_addr` = `dabt_addr`. Only the first abort while `xfer_busy` is continuously high does so; later aborts in the same transfer leave both registers unchanged.
- R10: With the enable clear, the fault registers keep their values.
- R11: When events coincide, the entry code priority is instruction breakpoint, then `dbp_hit`, then `bkpt_exec`. A PC-based fault (`bkpt_exec` or `pabt`) wins over a data abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control word, 1 breakpoint A, 2 breakpoint B |
| cfg_wdata | input | 32 | Configuration write data |
| pc_valid | input | 1 | `pc` holds an instruction about to execute |
| pc | input | 32 | Program counter of the current instruction |
| dbp_hit | input | 1 | Data-breakpoint hit strobe |
| bkpt_exec | input | 1 | Breakpoint instruction executing at `pc` |
| pabt | input | 1 | Prefetch abort at `pc` |
| dabt | input | 1 | Data abort strobe |
| dabt_addr | input | 32 | Address of the aborted data access |
| xfer_busy | input | 1 | High for the whole of a multi-word transfer |
| dbg_ctrl | output | 32 | Debug control word, including the entry code |
| fault_status | output | 32 | Recorded fault status |
| fault_addr | output | 32 | Recorded fault address |
| trap | output | 1 | One-cycle debug trap request |
| bkpt_nop | output | 1 | One-cycle pulse: breakpoint instruction completes as a no-op |

## Verification
The in-module assertions check on every cycle that:
- a trap only follows a cycle in which the enable was set;
- trap and no-op never appear together;
- the control word and fault registers hold while the enable is clear (unless software writes the control word);
- the code written for a breakpoint instruction is 3;
- a repeated abort in one transfer leaves the fault registers alone.

Only the directed scenarios can show:
- the exact codes for breakpoint and data-breakpoint entry;
- the bit-0 enable and word-granular PC match of the breakpoint registers;
- the recorded status and address values;
- the way a second transfer re-arms data-abort recording;
- the priority order when events coincide.

// File: rtl/dbg_entry_rec.sv
module dbg_entry_rec #(
  parameter int DW = 32,
  parameter int FS_PC = 'h400,
  parameter int FS_XFER = 'h001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          pc_valid,
  input  logic [DW-1:0] pc,
  input  logic          dbp_hit,
  input  logic          bkpt_exec,
  input  logic          pabt,
  input  logic          dabt,
  input  logic [DW-1:0] dabt_addr,
  input  logic          xfer_busy,
  output logic [DW-1:0] dbg_ctrl,
  output logic [DW-1:0] fault_status,
  output logic [DW-1:0] fault_addr,
  output logic          trap,
  output logic          bkpt_nop
);
  localparam int EN_BIT = DW - 1;
  localparam int MOE_LO = 2;
  localparam int MOE_HI = 4;
  localparam logic [2:0] MOE_IBP = 3'd1;
  localparam logic [2:0] MOE_DBP = 3'd2;
  localparam logic [2:0] MOE_BKPT = 3'd3;

  logic [DW-1:0] ctrl_q, ibpa_q, ibpb_q, fsr_q, far_q;
  logic          dabt_seen_q, trap_q, nop_q;

  wire dbg_en = ctrl_q[EN_BIT];
  wire hit_a = ibpa_q[0] && (pc[DW-1:2] == ibpa_q[DW-1:2]);
  wire hit_b = ibpb_q[0] && (pc[DW-1:2] == ibpb_q[DW-1:2]);
  wire ibp_hit = pc_valid && (hit_a || hit_b);
  wire moe_evt = ibp_hit || dbp_hit || bkpt_exec;
  wire [2:0] moe_code = ibp_hit ? MOE_IBP : (dbp_hit ? MOE_DBP : MOE_BKPT);
  wire ctrl_wr = cfg_we && (cfg_sel == 2'd0);
  wire pc_fault = bkpt_exec || pabt;
  wire dabt_first = dabt && !dabt_seen_q;

  logic [DW-1:0] ctrl_d;
  always_comb begin
    ctrl_d = ctrl_wr ? cfg_wdata : ctrl_q;
    if (dbg_en && moe_evt) ctrl_d[MOE_HI:MOE_LO] = moe_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      ibpa_q      <= '0;
      ibpb_q      <= '0;
      fsr_q       <= '0;
      far_q       <= '0;
      dabt_seen_q <= 1'b0;
      trap_q      <= 1'b0;
      nop_q       <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (cfg_we && cfg_sel == 2'd1) ibpa_q <= cfg_wdata;
      if (cfg_we && cfg_sel == 2'd2) ibpb_q <= cfg_wdata;
      dabt_seen_q <= xfer_busy && (dabt_seen_q || dabt);
      if (dbg_en) begin
        if (pc_fault) begin
          fsr_q <= DW'(FS_PC);
          far_q <= pc;
        end else if (dabt_first) begin
          fsr_q <= DW'(FS_XFER);
          far_q <= dabt_addr;
        end
      end
      trap_q <= dbg_en && moe_evt;
      nop_q  <= !dbg_en && bkpt_exec;
    end
  end

  assign dbg_ctrl     = ctrl_q;
  assign fault_status = fsr_q;
  assign fault_addr   = far_q;
  assign trap         = trap_q;
  assign bkpt_nop     = nop_q;

  p_trap_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(dbg_ctrl[EN_BIT]));
  p_trap_nop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap && bkpt_nop));
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_ctrl[EN_BIT] && !(cfg_we && cfg_sel == 2'd0)) |=> $stable(dbg_ctrl));
  p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_ctrl[EN_BIT] |=> ($stable(fault_status) && $stable(fault_addr)));
  p_bkpt_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ctrl[EN_BIT] && bkpt_exec && !dbp_hit && !ibp_hit) |=> (dbg_ctrl[MOE_HI:MOE_LO] == MOE_BKPT));
  p_dabt_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ctrl[EN_BIT] && dabt && dabt_seen_q && !pc_fault) |=> ($stable(fault_status) && $stable(fault_addr)));
endmodule

// File: tb/sim_dbg_entry_rec.sv
module sim_dbg_entry_rec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, pc_valid = 0, dbp_hit = 0, bkpt_exec = 0, pabt = 0, dabt = 0, xfer_busy = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, pc = 0, dabt_addr = 0;
  logic [31:0] dbg_ctrl, fault_status, fault_addr;
  logic trap, bkpt_nop;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dbg_entry_rec u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pc_valid(pc_valid), .pc(pc), .dbp_hit(dbp_hit),
    .bkpt_exec(bkpt_exec), .pabt(pabt), .dabt(dabt), .dabt_addr(dabt_addr),
    .xfer_busy(xfer_busy), .dbg_ctrl(dbg_ctrl), .fault_status(fault_status),
    .fault_addr(fault_addr), .trap(trap), .bkpt_nop(bkpt_nop));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    pc_valid = 0; dbp_hit = 0; bkpt_exec = 0; pabt = 0; dabt = 0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", dbg_ctrl, 0);
    chk("R1 fsr", fault_status, 0);
    chk("R1 far", fault_addr, 0);
    chk("R1 trap/nop", {30'd0, trap, bkpt_nop}, 0);
  endtask

  task automatic t_ibp();
    cfg(2'd1, 32'h0000_1001);
    cfg(2'd0, 32'h8000_0000);
    chk("R2 ctrl write", dbg_ctrl, 32'h8000_0000);
    pc = 32'h0000_1002; pc_valid = 1;
    settle();
    chk("R3 R5 ibp code", dbg_ctrl, 32'h8000_0004);
    chk("R6 trap ibp", {31'd0, trap}, 1);
    @(negedge clk);
    chk("R6 trap single cycle", {31'd0, trap}, 0);
    cfg(2'd0, 32'h8000_0000);
    cfg(2'd2, 32'h0000_2000);
    pc = 32'h0000_2000; pc_valid = 1;
    settle();
    chk("R5 bit0 clear no hit", dbg_ctrl, 32'h8000_0000);
    chk("R5 no trap", {31'd0, trap}, 0);
    cfg(2'd2, 32'h0000_2001);
    pc = 32'h0000_2003; pc_valid = 1;
    settle();
    chk("R5 second register", dbg_ctrl, 32'h8000_0004);
  endtask

  task automatic t_dbp();
    cfg(2'd0, 32'h8000_0100);
    dbp_hit = 1;
    settle();
    chk("R3 dbp code keeps other bits", dbg_ctrl, 32'h8000_0108);
    chk("R6 trap dbp", {31'd0, trap}, 1);
  endtask

  task automatic t_bkpt_en();
    cfg(2'd0, 32'h8000_0000);
    pc = 32'h0000_ABC0; bkpt_exec = 1;
    settle();
    chk("R3 bkpt code", dbg_ctrl, 32'h8000_000C);
    chk("R8 bkpt fsr", fault_status, 32'h400);
    chk("R8 bkpt far", fault_addr, 32'h0000_ABC0);
    chk("R6 R7 trap no nop", {30'd0, trap, bkpt_nop}, 32'd2);
  endtask

  task automatic t_bkpt_dis();
    cfg(2'd0, 32'h0000_0010);
    pc = 32'h0000_5550; bkpt_exec = 1;
    settle();
    chk("R7 nop no trap", {30'd0, trap, bkpt_nop}, 32'd1);
    chk("R4 ctrl held", dbg_ctrl, 32'h0000_0010);
    chk("R10 far held", fault_addr, 32'h0000_ABC0);
    @(negedge clk);
    chk("R7 nop single cycle", {31'd0, bkpt_nop}, 0);
  endtask

  task automatic t_pabt();
    cfg(2'd0, 32'h8000_0000);
    pc = 32'h0000_7770; pabt = 1;
    settle();
    chk("R8 pabt fsr", fault_status, 32'h400);
    chk("R8 pabt far", fault_addr, 32'h0000_7770);
    chk("R8 pabt no entry", dbg_ctrl, 32'h8000_0000);
  endtask

  task automatic t_dabt();
    cfg(2'd0, 32'h8000_0000);
    xfer_busy = 1; dabt = 1; dabt_addr = 32'h100;
    settle();
    chk("R9 first fsr", fault_status, 32'h001);
    chk("R9 first far", fault_addr, 32'h100);
    dabt = 1; dabt_addr = 32'h104;
    settle();
    chk("R9 later abort ignored", fault_addr, 32'h100);
    xfer_busy = 0;
    @(negedge clk);
    xfer_busy = 1; dabt = 1; dabt_addr = 32'h200;
    settle();
    chk("R9 new transfer", fault_addr, 32'h200);
    xfer_busy = 0;
  endtask

  task automatic t_disabled();
    cfg(2'd0, 32'h0000_0000);
    pc = 32'h0000_9990; pabt = 1;
    settle();
    chk("R10 pabt disabled", fault_addr, 32'h200);
    dabt = 1; dabt_addr = 32'h300;
    settle();
    chk("R10 dabt disabled fsr", fault_status, 32'h001);
    chk("R10 dabt disabled far", fault_addr, 32'h200);
    dbp_hit = 1;
    settle();
    chk("R4 dbp disabled ctrl", dbg_ctrl, 0);
    chk("R6 no trap disabled", {31'd0, trap}, 0);
  endtask

  task automatic t_prio();
    cfg(2'd0, 32'h8000_0000);
    pc = 32'h0000_1000; pc_valid = 1; dbp_hit = 1; bkpt_exec = 1;
    dabt = 1; dabt_addr = 32'h400;
    settle();
    chk("R11 ibp first", dbg_ctrl, 32'h8000_0004);
    chk("R11 pc fault over dabt fsr", fault_status, 32'h400);
    chk("R11 pc fault over dabt far", fault_addr, 32'h0000_1000);
    pc = 32'h0000_6000; dbp_hit = 1; bkpt_exec = 1;
    settle();
    chk("R11 dbp over bkpt", dbg_ctrl, 32'h8000_0008);
  endtask

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ibp();
    t_dbp();
    t_bkpt_en();
    t_bkpt_dis();
    t_pabt();
    t_dabt();
    t_disabled();
    t_prio();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule